// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Array

The block models a fuse-programmed logic array whose eight outputs are all registered. A fuse map of 64 rows by 32 columns is written one row at a time through a write port while a program-enable input is high. Each row forms one product term over 16 array signals, each offered in true and complement form. The 16 signals are eight dedicated inputs plus the eight register outputs fed back. Each output register takes the OR of its own group of eight product terms on every rising clock edge.

The register contents leave the block inverted, on pins that carry a separate drive-enable flag to stand in for a three-state buffer. Reset stands in for power-up and sets every register, so the enabled pins read low. A preload mode releases the pins and loads each register from the level applied externally to its pin. This lets a test place the state machine in any state directly and then read that state back at the pins.

Top module: `sop_reg_array`

## Requirements
- R1: While `rst_n` is low every register is 1, so `q_pin` reads all zeros. With `oe_n` low and preload off, `q_drive` is 1.
- R2: A write to the fuse row `prog_row` takes effect at a rising edge only when `prog_en` and `prog_we` are both high. A write attempted with `prog_en` low leaves the array's logic unchanged.
- R3: Fuse bit c of row r (fuse number 32·r + c) belongs to column c. Column 2k carries array signal k and column 2k+1 carries its complement. Signals 0 to 7 are `din[0]` to `din[7]`, and signals 8 to 15 are register outputs 0 to 7.
- R4: A fuse bit of 1 connects its column into the product term, and a 0 leaves the column out. A row with every bit 1 is always false. A row with every bit 0 is always true.
- R5: At each rising edge outside preload, register j loads the OR of rows 8·j to 8·j+7.
- R6: `q_pin` equals the bitwise inverse of the registers at all times. `q_drive` is 1 exactly when `oe_n` is low and `preload_en` is low.
- R7: While `preload_en` is high, each rising edge loads register j with the inverse of `pin_in[j]`, so `q_pin` then reads back the applied `pin_in`. The fuse logic and `din` are ignored during preload.
- R8: Feedback columns carry the register values from before the current edge, so a programmed counter advances by exactly one per enabled edge and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common register clock |
| rst_n | input | 1 | Asynchronous active-low power-up set |
| prog_en | input | 1 | Unlocks fuse map writes |
| prog_we | input | 1 | Fuse row write strobe |
| prog_row | input | 6 | Fuse row (product term) address |
| prog_bits | input | 32 | Fuse bits for the addressed row |
| din | input | 8 | Dedicated array inputs |
| oe_n | input | 1 | Active-low output enable |
| preload_en | input | 1 | Preload mode select |
| pin_in | input | 8 | Level applied to the output pins during preload |
| q_pin | output | 8 | Inverted register contents |
| q_drive | output | 1 | Pins are driven when 1 |

## Verification
The bench programs a 4-bit up-counter with a count enable into the array, along with three registered pass-through outputs and one output built only from rows that are always false. It then compares every cycle against an arithmetic model. The counter wraps from the power-up value 15 to 0. A design that swapped the true and complement columns, or that fed back the next state instead of the current state, would miscount at once. A fuse write attempted while locked must leave the always-false output low; a design that ignored the lock would turn it high. Preload must read back the applied pin levels and release the pins, and the counter must then resume from the preloaded state. An uninverted preload path would show the complement at the pins.

// File: rtl/sop_reg_array.sv
module sop_reg_array #(
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int TPO  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prog_en,
  input  logic                              prog_we,
  input  logic [$clog2(NOUT*TPO)-1:0]       prog_row,
  input  logic [2*(NIN+NOUT)-1:0]           prog_bits,
  input  logic [NIN-1:0]                    din,
  input  logic                              oe_n,
  input  logic                              preload_en,
  input  logic [NOUT-1:0]                   pin_in,
  output logic [NOUT-1:0]                   q_pin,
  output logic                              q_drive
);
  localparam int NSIG = NIN + NOUT;
  localparam int NCOL = 2 * NSIG;
  localparam int NROW = NOUT * TPO;

  logic [NROW-1:0][NCOL-1:0] fuse;
  logic [NOUT-1:0] state, next_d;
  logic [NSIG-1:0] sig;
  logic [NCOL-1:0] col;
  logic [NROW-1:0] pterm;

  assign sig = {state, din};

  for (genvar k = 0; k < NSIG; k++) begin : g_col
    assign col[2*k]   = sig[k];
    assign col[2*k+1] = ~sig[k];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_term
    assign pterm[r] = &(col | ~fuse[r]);
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_sum
    assign next_d[j] = |pterm[j*TPO +: TPO];
  end

  always_ff @(posedge clk)
    if (prog_en && prog_we) fuse[prog_row] <= prog_bits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          state <= '1;
    else if (preload_en) state <= ~pin_in;
    else                 state <= next_d;

  assign q_pin   = ~state;
  assign q_drive = ~oe_n & ~preload_en;
endmodule

// File: rtl/sop_reg_array_chk.sv
module sop_reg_array_chk #(
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int TPO  = 8
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          prog_en,
  input logic                                          oe_n,
  input logic                                          preload_en,
  input logic [NOUT-1:0]                               pin_in,
  input logic [NOUT-1:0]                               q_pin,
  input logic                                          q_drive,
  input logic [NOUT-1:0]                               next_d,
  input logic [NOUT*TPO-1:0][2*(NIN+NOUT)-1:0]         fuse
);
  assert_powerup_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q_pin == '0);

  assert_fuse_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(fuse));

  assert_sum_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en |=> q_pin == ~$past(next_d));

  assert_pins_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || preload_en) |-> !q_drive);

  assert_preload_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> q_pin == $past(pin_in));
endmodule

bind sop_reg_array sop_reg_array_chk #(.NIN(NIN), .NOUT(NOUT), .TPO(TPO)) chk_i (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .oe_n(oe_n),
  .preload_en(preload_en), .pin_in(pin_in), .q_pin(q_pin),
  .q_drive(q_drive), .next_d(next_d), .fuse(fuse)
);

// File: tb/sop_reg_array_test.sv
module sop_reg_array_test;
  logic clk = 0, rst_n = 0, prog_en = 0, prog_we = 0, oe_n = 0, preload_en = 0;
  logic [5:0] prog_row = '0;
  logic [31:0] prog_bits = '0;
  logic [7:0] din = '0, pin_in = '0, q_pin;
  logic q_drive;
  logic [7:0] m;
  logic blown56 = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  sop_reg_array uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] lit(int s, int neg);
    return 32'd1 << (2*s + neg);
  endfunction

  // R3 column map, R4 intact = connected, unused rows all intact (false)
  function automatic logic [31:0] row_bits(int r);
    int o = r / 8, t = r % 8;
    logic [31:0] b;
    if (o < 4) begin
      if (t <= o) return lit(8+o, 0) | (t == 0 ? lit(0, 1) : lit(8+t-1, 1));
      if (t == o + 1) begin
        b = lit(8+o, 1) | lit(0, 0);
        for (int i = 0; i < o; i++) b |= lit(8+i, 0);
        return b;
      end
      return '1;
    end
    if (o < 7 && t == 0) return lit(o, 0);
    return '1;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] n;
    if (preload_en) n = ~pin_in;
    else begin
      n[3:0] = din[0] ? m[3:0] + 4'd1 : m[3:0];
      n[6:4] = din[6:4];
      n[7]   = blown56;
    end
    @(posedge clk); #1;
    if (rst_n) m = n;
    if (prog_en && prog_we && prog_row == 6'd56) blown56 = (prog_bits == '0);
  endtask

  task automatic run(int cycles, int seed);
    for (int i = 0; i < cycles; i++) begin
      din = 8'((i * 37 + seed) ^ (i >> 1));
      din[0] = ((i * 5 + seed) % 7) != 2;
      tick();
      check(q_pin == ~m, "R5/R8 counter", q_pin, ~m);
    end
  endtask

  initial begin
    #1;
    prog_en = 1; prog_we = 1;
    for (int r = 0; r < 64; r++) begin
      prog_row = 6'(r); prog_bits = row_bits(r);
      @(posedge clk); #1;
    end
    prog_en = 0; prog_we = 0;
    check(q_pin == 8'h00, "R1 pins low in reset", q_pin, 8'h00);
    check(q_drive == 1'b1, "R1 drive", {7'd0, q_drive}, 8'h01);
    m = 8'hFF;
    rst_n = 1;
    check(q_pin == 8'h00, "R1 pins low after release", q_pin, 8'h00);
    run(48, 3);
    // R4 all-intact output 7 stays low internally, so its pin reads 1
    check(q_pin[7] == 1'b1, "R4 all-intact false", q_pin, {1'b1, q_pin[6:0]});
    // R2 locked write ignored
    prog_we = 1; prog_row = 6'd56; prog_bits = '0;
    tick(); tick();
    check(q_pin[7] == 1'b1, "R2 locked write ignored", q_pin, ~m);
    prog_en = 1; tick(); prog_en = 0; prog_we = 0;
    tick();
    check(q_pin[7] == 1'b0, "R4 all-blown true", q_pin, ~m);
    run(10, 11);
    // R6 output enable
    oe_n = 1; #1;
    check(q_drive == 1'b0, "R6 oe_n high releases", {7'd0, q_drive}, 8'h00);
    run(4, 5);
    oe_n = 0; #1;
    check(q_drive == 1'b1, "R6 oe_n low drives", {7'd0, q_drive}, 8'h01);
    // R7 preload
    foreach (pin_in[i]) pin_in[i] = i[0];
    preload_en = 1; pin_in = 8'h5A; din = 8'hFF; #1;
    check(q_drive == 1'b0, "R7 pins released in preload", {7'd0, q_drive}, 8'h00);
    tick();
    check(q_pin == 8'h5A, "R7 preload readback", q_pin, 8'h5A);
    pin_in = 8'hF0; tick();
    check(q_pin == 8'hF0, "R7 preload readback 2", q_pin, 8'hF0);
    preload_en = 0;
    run(24, 1);
    preload_en = 1; pin_in = 8'h01; tick(); preload_en = 0;
    check(q_pin == 8'h01, "R7 preload near wrap", q_pin, 8'h01);
    run(8, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule